// File: doc/BRIEF.md
# Acquire/Release Cache Maintenance Sequencer

This block sits between a compute unit's memory request port and its first-level data cache. It makes memory-ordering flags take effect on the cache. An acquire invalidates every block of the cache, so later loads cannot see stale data. A release writes every block back, so earlier stores become visible. Each walk visits every block index in turn. It hands one maintenance request per cycle to the cache over a valid/ready handshake, and it counts each request as outstanding until the cache acknowledges it.

While any writeback work remains (queued, being walked or unacknowledged), ordinary requests are refused. Kernel-scope requests are always taken. A kernel end is parked in a per-context pending mask. All parked kernel ends are reported together in the cycle after the writeback work drains. A kernel begin that arrives during a writeback drain starts an invalidate walk only when no invalidate work is already in flight. Walk requests that arrive while a walk is running are queued, not dropped.

Top module: `maint_seq`

## Requirements
- R1: An accepted release starts a writeback walk. The walk issues exactly NBLK maintenance requests with `m_wb`=1 and `m_idx` counting 0, 1, ..., NBLK-1 in ascending order. Each accepted request raises `wb_out` by one.
- R2: An accepted acquire starts an invalidate walk. It issues NBLK requests with `m_wb`=0 and ascending `m_idx`, and each accepted request raises `inv_out` by one.
- R3: A non-kernel request carrying both flags performs the complete invalidate walk first, then the complete writeback walk.
- R4: While `wb_out` is nonzero, or a writeback walk is running or queued, `req_ready` is 0 for requests with `req_kern`=0. `req_ready` is always 1 when `req_kern`=1.
- R5: During writeback work, a kernel end (`req_kern`=1, `req_rel`=1) is recorded and starts no walk. A kernel begin (`req_kern`=1, `req_acq`=1) starts an invalidate walk only if `inv_out` is 0 and no invalidate walk is running or queued. Otherwise it has no effect.
- R6: `kend_done` pulses for one cycle with bit c set for every recorded kernel end of context `req_ctx`=c. The pulse comes in the cycle after writeback work becomes empty, and never while `wb_out` is nonzero.
- R7: `wb_ack` lowers `wb_out` by one and `inv_ack` lowers `inv_out` by one. A nonzero `inv_out` never holds `req_ready` or `kend_done` back.
- R8: An acknowledgement that arrives while its count is 0 raises `ack_err` for one cycle in the next cycle and leaves the count at 0.
- R9: At most one maintenance request completes per cycle (`m_valid` and `m_ready` both 1). While `m_valid`=1 and `m_ready`=0, `m_idx` and `m_wb` hold their values and `m_valid` stays 1.
- R10: `inv_out` and `wb_out` never exceed 2*NBLK. A queued invalidate walk starts only once `inv_out` is at most NBLK.
- R11: A walk requested while another walk runs is queued and then performed in full. A non-kernel request is refused while an invalidate walk is queued, so no requested walk is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_acq | input | 1 | Acquire ordering flag |
| req_rel | input | 1 | Release ordering flag |
| req_kern | input | 1 | Kernel-scope request (begin with acquire, end with release) |
| req_ctx | input | CW | Context of a kernel-scope request |
| m_valid | output | 1 | Maintenance request valid |
| m_ready | input | 1 | Cache accepts maintenance request |
| m_wb | output | 1 | 1 = writeback, 0 = invalidate |
| m_idx | output | IW | Cache block index |
| wb_ack | input | 1 | One writeback acknowledged |
| inv_ack | input | 1 | One invalidate acknowledged |
| wb_out | output | CNTW | Outstanding writebacks |
| inv_out | output | CNTW | Outstanding invalidates |
| kend_done | output | NCTX | Kernel-end completion pulse, one bit per context |
| ack_err | output | 1 | Acknowledgement arrived at zero count |

## Verification
The bench lets acknowledgements arrive while a writeback walk is still running. The count then reaches zero mid-walk, and a design that watched only the counter would report a kernel end too early. A kernel end and a kernel begin are sent during a held drain. A design that treated them like ordinary requests would block them or start a second writeback walk. Three back-to-back acquires push the invalidate count to its limit with acknowledgements held. A design that dropped queued walks would lose requests, and one without the start gate would let the counter wrap. Stalled handshakes and acknowledgements at a zero count check for an index that advances without acceptance and for a counter that wraps below zero.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic {
    WALK_INV = 1'b0,
    WALK_WB  = 1'b1
  } walk_kind_e;
endpackage

// File: rtl/msq_walker.sv
module msq_walker
  import msq_pkg::*;
#(
  parameter int NBLK = 64,
  parameter int IW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  walk_kind_e    start_kind,
  input  logic          m_ready,
  output logic          m_valid,
  output walk_kind_e    m_kind,
  output logic [IW-1:0] m_idx
);
  localparam logic [IW-1:0] LAST = IW'(NBLK - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_kind  <= WALK_INV;
      m_idx   <= '0;
    end else if (!m_valid) begin
      if (start) begin
        m_valid <= 1'b1;
        m_kind  <= start_kind;
        m_idx   <= '0;
      end
    end else if (m_ready) begin
      if (m_idx == LAST) m_valid <= 1'b0;
      else               m_idx   <= m_idx + 1'b1;
    end
  end

  // R9: a stalled request keeps its index and kind
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_idx) && $stable(m_kind)));

  assert_idx_range_R1: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_idx <= LAST));
endmodule

// File: rtl/msq_outcnt.sv
module msq_outcnt #(
  parameter int MAXV = 128,
  parameter int W    = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         err
);
  logic take;
  assign take = dec && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      err <= dec && (cnt == '0);
      cnt <= cnt + W'(inc) - W'(take);
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    cnt <= W'(MAXV));

  // R8: acknowledgement at zero flags an error and keeps the count at zero
  assert_zero_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && cnt == '0) |=> (err && cnt == '0));
endmodule

// File: rtl/maint_seq.sv
module maint_seq
  import msq_pkg::*;
#(
  parameter int NBLK = 64,
  parameter int NCTX = 4,
  localparam int IW   = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int CW   = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int CMAX = 2 * NBLK,
  localparam int CNTW = $clog2(CMAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_acq,
  input  logic            req_rel,
  input  logic            req_kern,
  input  logic [CW-1:0]   req_ctx,
  output logic            m_valid,
  input  logic            m_ready,
  output logic            m_wb,
  output logic [IW-1:0]   m_idx,
  input  logic            wb_ack,
  input  logic            inv_ack,
  output logic [CNTW-1:0] wb_out,
  output logic [CNTW-1:0] inv_out,
  output logic [NCTX-1:0] kend_done,
  output logic            ack_err
);
  walk_kind_e cur_kind, start_kind;
  logic inv_q, wb_q;
  logic wb_busy, inv_busy, acc;
  logic set_inv, set_wb, start_inv, start_wb;
  logic wb_fire, inv_fire, wb_err, inv_err;
  logic [NCTX-1:0] kend_pend, kend_add;

  assign m_wb     = (cur_kind == WALK_WB);
  assign wb_fire  = m_valid && m_ready && m_wb;
  assign inv_fire = m_valid && m_ready && !m_wb;

  assign wb_busy  = (wb_out != '0)  || wb_q  || (m_valid && m_wb);
  assign inv_busy = (inv_out != '0) || inv_q || (m_valid && !m_wb);

  assign req_ready = req_kern || (!wb_busy && !inv_q);
  assign acc       = req_valid && req_ready;

  always_comb begin
    set_inv  = 1'b0;
    set_wb   = 1'b0;
    kend_add = '0;
    if (acc) begin
      if (req_kern) begin
        set_inv = req_acq && (!wb_busy || !inv_busy);
        set_wb  = req_rel && !wb_busy;
        if (req_rel && int'(req_ctx) < NCTX) kend_add[req_ctx] = 1'b1;
      end else begin
        set_inv = req_acq;
        set_wb  = req_rel;
      end
    end
  end

  // invalidate walk first when both are queued
  assign start_inv  = !m_valid && inv_q && (inv_out <= CNTW'(NBLK));
  assign start_wb   = !m_valid && !inv_q && wb_q;
  assign start_kind = start_inv ? WALK_INV : WALK_WB;

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q     <= 1'b0;
      wb_q      <= 1'b0;
      kend_pend <= '0;
      kend_done <= '0;
    end else begin
      inv_q <= (inv_q && !start_inv) || set_inv;
      wb_q  <= (wb_q && !start_wb) || set_wb;
      if (!wb_busy && kend_pend != '0) begin
        kend_done <= kend_pend;
        kend_pend <= kend_add;
      end else begin
        kend_done <= '0;
        kend_pend <= kend_pend | kend_add;
      end
    end
  end

  msq_walker #(.NBLK(NBLK), .IW(IW)) u_walker (
    .clk(clk), .rst(rst),
    .start(start_inv || start_wb), .start_kind(start_kind),
    .m_ready(m_ready), .m_valid(m_valid), .m_kind(cur_kind), .m_idx(m_idx)
  );

  msq_outcnt #(.MAXV(CMAX), .W(CNTW)) u_wb_cnt (
    .clk(clk), .rst(rst), .inc(wb_fire), .dec(wb_ack), .cnt(wb_out), .err(wb_err)
  );

  msq_outcnt #(.MAXV(CMAX), .W(CNTW)) u_inv_cnt (
    .clk(clk), .rst(rst), .inc(inv_fire), .dec(inv_ack), .cnt(inv_out), .err(inv_err)
  );

  assign ack_err = wb_err || inv_err;

  assert_issue_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (wb_out != '0 && !req_kern) |-> !req_ready);

  assert_kend_drained_R6: assert property (@(posedge clk) disable iff (rst)
    (kend_done != '0) |-> (wb_out == '0));

  assert_kern_ready_R4: assert property (@(posedge clk) disable iff (rst)
    req_kern |-> req_ready);

  assert_inv_start_R10: assert property (@(posedge clk) disable iff (rst)
    ($rose(m_valid) && !m_wb) |-> ($past(inv_out) <= CNTW'(NBLK)));
endmodule

// File: tb/maint_seq_tb.sv
module maint_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 8;
  localparam int NCTX = 4;
  localparam int IW   = 3;
  localparam int CW   = 2;
  localparam int CNTW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_acq = 0, req_rel = 0, req_kern = 0;
  logic [CW-1:0] req_ctx = '0;
  logic req_ready, m_valid, m_wb;
  logic m_ready = 1'b1;
  logic [IW-1:0] m_idx;
  logic wb_ack = 0, inv_ack = 0;
  logic [CNTW-1:0] wb_out, inv_out;
  logic [NCTX-1:0] kend_done;
  logic ack_err;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  int wb_owe = 0, inv_owe = 0, man_wb = 0, man_inv = 0;
  bit auto_ack = 0, rdy_mode = 0, finished = 0;
  logic [NCTX-1:0] kend_seen = '0;
  int err_seen = 0, hold_cnt = 0, cyc = 0;
  logic hold_prev = 0, hold_kind = 0;
  logic [IW-1:0] hold_idx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  maint_seq #(.NBLK(NBLK), .NCTX(NCTX)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_acq(req_acq), .req_rel(req_rel), .req_kern(req_kern), .req_ctx(req_ctx),
    .m_valid(m_valid), .m_ready(m_ready), .m_wb(m_wb), .m_idx(m_idx),
    .wb_ack(wb_ack), .inv_ack(inv_ack), .wb_out(wb_out), .inv_out(inv_out),
    .kend_done(kend_done), .ack_err(ack_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_walk(input bit wb);
    for (int i = 0; i < NBLK; i++) exp_q.push_back((wb ? 256 : 0) + i);
  endtask

  task automatic send(input bit acq, input bit rel, input bit kern, input int ctx);
    @(posedge clk); #1;
    req_acq = acq; req_rel = rel; req_kern = kern; req_ctx = CW'(ctx); req_valid = 1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0; req_acq = 0; req_rel = 0; req_kern = 0;
  endtask

  task automatic probe_ready(input bit kern, output logic r);
    @(posedge clk); #1; req_kern = kern;
    @(negedge clk); r = req_ready;
    #1 req_kern = 0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!m_valid && wb_out == 0 && inv_out == 0 && exp_q.size() == 0 &&
          wb_owe == 0 && inv_owe == 0) q++;
      else q = 0;
      if (q >= 4) break;
    end
  endtask

  // maintenance-port readiness
  always @(posedge clk) begin
    #1;
    cyc++;
    m_ready = rdy_mode ? (cyc % 3 != 2) : 1'b1;
  end

  // acknowledgement driver
  always @(posedge clk) begin
    #1;
    wb_ack = 0; inv_ack = 0;
    if (!rst) begin
      if ((auto_ack && wb_owe > 0) || man_wb > 0) begin
        wb_ack = 1;
        if (man_wb > 0) man_wb--;
        if (wb_owe > 0) wb_owe--;
      end
      if ((auto_ack && inv_owe > 0) || man_inv > 0) begin
        inv_ack = 1;
        if (man_inv > 0) man_inv--;
        if (inv_owe > 0) inv_owe--;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (m_valid && hold_prev) begin
        hold_cnt++;
        chk(m_idx == hold_idx && m_wb == hold_kind, "R9 stalled request changed",
            int'(m_idx), int'(hold_idx));
      end
      hold_prev = m_valid && !m_ready;
      hold_idx  = m_idx;
      hold_kind = m_wb;
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R11 unexpected maintenance request", (m_wb ? 256 : 0) + int'(m_idx), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(((m_wb ? 256 : 0) + int'(m_idx)) == e, m_wb ? "R1 writeback order" : "R2 invalidate order",
              (m_wb ? 256 : 0) + int'(m_idx), e);
        end
        if (m_wb) wb_owe++; else inv_owe++;
      end
      kend_seen = kend_seen | kend_done;
      if (ack_err) err_seen++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic r;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(m_valid == 0 && wb_out == 0 && inv_out == 0, "R9 reset idle", int'(m_valid), 0);
    chk(kend_done == 0 && ack_err == 0 && req_ready == 1, "R4 reset ready", int'(req_ready), 1);

    // kernel end with acks returning during the walk
    auto_ack = 1;
    push_walk(1);
    send(0, 1, 1, 1);
    wait_quiet();
    chk(kend_seen == 4'b0010, "R6 kernel end reported", int'(kend_seen), 2);
    chk(exp_q.size() == 0, "R1 full writeback walk", exp_q.size(), 0);
    kend_seen = '0;

    // held drain: release with no acks
    auto_ack = 0;
    push_walk(1);
    send(0, 1, 0, 0);
    repeat (20) @(negedge clk);
    chk(wb_out == NBLK, "R1 writeback count", int'(wb_out), NBLK);
    probe_ready(0, r);
    chk(r == 0, "R4 normal issue held", int'(r), 0);
    probe_ready(1, r);
    chk(r == 1, "R4 kernel request taken", int'(r), 1);
    send(0, 1, 1, 2);
    push_walk(0);
    send(1, 0, 1, 0);
    repeat (20) @(negedge clk);
    chk(inv_out == NBLK, "R5 kernel begin walks", int'(inv_out), NBLK);
    send(1, 0, 1, 3);
    repeat (20) @(negedge clk);
    chk(inv_out == NBLK && exp_q.size() == 0, "R5 second kernel begin ignored", int'(inv_out), NBLK);
    chk(wb_out == NBLK, "R5 kernel end starts no walk", int'(wb_out), NBLK);
    man_wb = NBLK - 1;
    repeat (12) @(negedge clk);
    chk(wb_out == 1, "R7 writeback acks decrement", int'(wb_out), 1);
    chk(kend_seen == 0, "R6 no early kernel end", int'(kend_seen), 0);
    man_wb = 1;
    repeat (4) @(negedge clk);
    chk(kend_seen == 4'b0100, "R6 kernel end after drain", int'(kend_seen), 4);
    probe_ready(0, r);
    chk(r == 1 && inv_out == NBLK, "R7 invalidates do not block", int'(r), 1);
    auto_ack = 1;
    wait_quiet();
    chk(inv_out == 0, "R7 invalidate acks decrement", int'(inv_out), 0);
    kend_seen = '0;

    // combined acquire+release under backpressure
    rdy_mode = 1;
    push_walk(0); push_walk(1);
    send(1, 1, 0, 0);
    wait_quiet();
    chk(exp_q.size() == 0, "R3 invalidate then writeback", exp_q.size(), 0);
    chk(hold_cnt > 0, "R9 stalls observed", hold_cnt, 1);
    rdy_mode = 0;

    // queued invalidate walks at the counter limit
    auto_ack = 0;
    push_walk(0); push_walk(0); push_walk(0);
    send(1, 0, 0, 0);
    send(1, 0, 0, 0);
    send(1, 0, 0, 0);
    repeat (30) @(negedge clk);
    chk(inv_out == 2 * NBLK, "R10 count at limit", int'(inv_out), 2 * NBLK);
    chk(m_valid == 0, "R10 queued walk waits", int'(m_valid), 0);
    probe_ready(0, r);
    chk(r == 0, "R11 refused while walk queued", int'(r), 0);
    auto_ack = 1;
    wait_quiet();
    chk(exp_q.size() == 0, "R11 queued walks all performed", exp_q.size(), 0);

    // acknowledgements at zero
    auto_ack = 0;
    err_seen = 0;
    man_wb = 1;
    repeat (4) @(negedge clk);
    chk(err_seen == 1 && wb_out == 0, "R8 writeback ack at zero", err_seen, 1);
    man_inv = 1;
    repeat (4) @(negedge clk);
    chk(err_seen == 2 && inv_out == 0, "R8 invalidate ack at zero", err_seen, 2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule